// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block gathers up to 256 interrupt sources behind one host interrupt line. Sources are organised in groups of eight, called blocks, and blocks are grouped eight at a time under a master. Software reaches any single source indirectly. It writes a block number into a select register, then uses three byte-wide windows to reach the selected block: one to program trigger settings, one to read latched pending bits and one to read the live input levels.

Each source can trigger on an edge or on a level. Each polarity has its own mask, and the source latches a pending bit. A three-level summary reports where pending bits are. Each master register holds one bit per block that has anything pending. The root register holds one bit per master that is non-zero. An interrupt handler reads the root first, follows the set master bits, selects the blocks those bits name and reads their latched status. It then clears each source with a configuration write.

Top module: `irq_aggregator`

## Requirements
- R1: Relative to BASE, the register offsets are: 0 root (read), 1 to 4 masters 0 to 3 (read), 5 block select (read and write), 6 latched status of the selected block (read), 7 source configuration (write), 8 raw status of the selected block (read). Any other address reads 0.
- R2: Source n sits in block n/8 at bit n%8. Block b sits in master b/8 at bit b%8.
- R3: Root bit 0 always reads 0, and master m is reported at root bit m+1.
- R4: A master bit is 1 exactly when its block has at least one latched pending bit. A root bit is 1 exactly when its master register is non-zero.
- R5: A write to offset 7 changes the source at bit wr_data[6:4] of the selected block, and it does so only when wr_data[7] is 1. Otherwise the write has no effect.
- R6: With configuration bit 0 at 0 the source is edge-triggered. A rising edge sets pending unless bit 2 is set, and a falling edge sets pending unless bit 1 is set.
- R7: With configuration bit 0 at 1 the source is level-triggered. A high level sets pending unless bit 2 is set, and a low level sets pending unless bit 1 is set. If the level is still active after a clear, pending sets again.
- R8: A strobed configuration write with bit 3 set clears the source's pending bit. The write stores the new trigger settings in the same cycle.
- R9: A source whose bits 1 and 2 are both set is disabled. Its pending bit is cleared by that write, and it never sets while both masks stay set.
- R10: A read of offset 8 returns the eight input levels of the selected block after a two-flop synchronizer, without latching.
- R11: irq_o is 1 exactly when the root register is non-zero.
- R12: After reset, every pending bit is 0, every source is edge mode with both masks set, and the select register is 0. When the select register names a block beyond the last one, the latched and raw windows read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source levels |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe for wr_data at addr |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr (combinational) |
| irq_o | output | 1 | Summary interrupt to the host |

## Verification
The hardest case to reach from the ports is one where pending bits in two different masters are live at the same time as a disabled source and a level source that re-latches after a clear. In that case the summary tree has to merge several branches and then drop them one at a time. The stimulus reaches it in steps. It enables a rising-edge source in block 1 and a high-level source in block 25. It raises both inputs and reads the root to see the two branches combined. It then disables the level source while its input is still high, toggles that input, and clears the edge source last, checking the root and irq_o after each step.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   // register offsets relative to BASE
   localparam int OFS_ROOT  = 0;
   localparam int OFS_MST0  = 1;
   localparam int MST_REGS  = 4;
   localparam int OFS_SEL   = 5;
   localparam int OFS_LATCH = 6;
   localparam int OFS_CFG   = 7;
   localparam int OFS_RAW   = 8;
   localparam int OFS_LAST  = 8;

   // configuration byte fields
   localparam int CB_LEVEL = 0;
   localparam int CB_MLO   = 1;
   localparam int CB_MHI   = 2;
   localparam int CB_CLR   = 3;
   localparam int CB_IDX   = 4;
   localparam int CB_STB   = 7;

   localparam int LANES = 8;

   typedef struct packed {
      logic mask_hi;
      logic mask_lo;
      logic level;
   } src_cfg_t;

   localparam src_cfg_t CFG_RESET = '{mask_hi: 1'b1, mask_lo: 1'b1, level: 1'b0};
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q;
   logic [W-1:0] stab_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
      end else begin
         meta_q <= d_i;
         stab_q <= meta_q;
      end
   end

   assign q_o = stab_q;
endmodule

// File: rtl/irqagg_block.sv
module irqagg_block
   import irqagg_pkg::*;
#(
   parameter int NL = LANES,
   localparam int IW = $clog2(NL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NL-1:0]   lvl_i,
   input  logic            cfg_we,
   input  logic [IW-1:0]   cfg_idx,
   input  src_cfg_t        cfg_wdata,
   input  logic            clr_i,
   output logic [NL-1:0]   pend_o,
   output logic [NL*3-1:0] cfg_o
);
   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic     prev_r;
      logic     pend_r;
      src_cfg_t cfg_r;
      logic     hit;
      logic     rise;
      logic     fall;
      logic     evt;
      logic     kill;

      assign hit  = cfg_we && (cfg_idx == IW'(i));
      assign rise = lvl_i[i] & ~prev_r;
      assign fall = ~lvl_i[i] & prev_r;
      assign kill = clr_i | (cfg_wdata.mask_hi & cfg_wdata.mask_lo);

      always_comb begin
         if (cfg_r.level)
            evt = (lvl_i[i] & ~cfg_r.mask_hi) | (~lvl_i[i] & ~cfg_r.mask_lo);
         else
            evt = (rise & ~cfg_r.mask_hi) | (fall & ~cfg_r.mask_lo);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_r <= 1'b0;
            pend_r <= 1'b0;
            cfg_r  <= CFG_RESET;
         end else begin
            prev_r <= lvl_i[i];
            if (hit)
               cfg_r <= cfg_wdata;
            if (hit && kill)
               pend_r <= 1'b0;
            else if (evt)
               pend_r <= 1'b1;
         end
      end

      assign pend_o[i]       = pend_r;
      assign cfg_o[i*3 +: 3] = cfg_r;
   end
endmodule

// File: rtl/irqagg_tree.sv
module irqagg_tree #(
   parameter int NUM_BLK = 32,
   parameter int NUM_MST = 4
) (
   input  logic [NUM_BLK-1:0]   blk_any_i,
   output logic [NUM_MST*8-1:0] mst_o,
   output logic [7:0]           root_o
);
   assign mst_o = (NUM_MST*8)'(blk_any_i);

   for (genvar r = 0; r < 8; r++) begin : g_root
      if (r >= 1 && r - 1 < NUM_MST) begin : g_live
         assign root_o[r] = |mst_o[(r-1)*8 +: 8];
      end else begin : g_zero
         assign root_o[r] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqagg_pkg::*;
#(
   parameter int          NUM_SRC = 256,
   parameter int          ADDR_W  = 10,
   parameter int unsigned BASE    = 'h1C0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [7:0]         wr_data,
   output logic [7:0]         rd_data,
   output logic               irq_o
);
   localparam int NUM_BLK = NUM_SRC / LANES;
   localparam int NUM_MST = (NUM_BLK + 7) / 8;
   localparam int BIW     = $clog2(NUM_BLK);
   localparam int TABN    = 2 ** BIW;
   localparam logic [ADDR_W-1:0] A_ROOT  = ADDR_W'(BASE + OFS_ROOT);
   localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(BASE + OFS_SEL);
   localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(BASE + OFS_LATCH);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(BASE + OFS_CFG);
   localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(BASE + OFS_RAW);

   if (NUM_SRC % LANES != 0 || NUM_SRC < 16 || NUM_SRC > 256) begin : g_bad_src
      $error("irq_aggregator: NUM_SRC must be a multiple of 8 in 16..256");
   end
   if (BASE + OFS_LAST >= 2 ** ADDR_W) begin : g_bad_base
      $error("irq_aggregator: register window exceeds address space");
   end

   logic [NUM_SRC-1:0]   src_s;
   logic [NUM_SRC-1:0]   pend_all;
   logic [NUM_SRC*3-1:0] cfg_all;
   logic [NUM_BLK-1:0]   blk_any;
   logic [NUM_MST*8-1:0] mst_bits;
   logic [7:0]           root;
   logic [7:0]           blk_sel;
   logic                 cfg_stb;
   src_cfg_t             cfg_new;

   irqagg_sync #(.W(NUM_SRC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         blk_sel <= '0;
      else if (wr_en && addr == A_SEL)
         blk_sel <= wr_data;
   end

   assign cfg_stb = wr_en && (addr == A_CFG) && wr_data[CB_STB];
   assign cfg_new = '{mask_hi: wr_data[CB_MHI], mask_lo: wr_data[CB_MLO],
                      level: wr_data[CB_LEVEL]};

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      irqagg_block #(.NL(LANES)) u_blk (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl_i     (src_s[b*LANES +: LANES]),
         .cfg_we    (cfg_stb && (blk_sel == 8'(b))),
         .cfg_idx   (wr_data[CB_IDX +: 3]),
         .cfg_wdata (cfg_new),
         .clr_i     (wr_data[CB_CLR]),
         .pend_o    (pend_all[b*LANES +: LANES]),
         .cfg_o     (cfg_all[b*LANES*3 +: LANES*3])
      );
      assign blk_any[b] = |pend_all[b*LANES +: LANES];
   end

   irqagg_tree #(.NUM_BLK(NUM_BLK), .NUM_MST(NUM_MST)) u_tree (
      .blk_any_i (blk_any),
      .mst_o     (mst_bits),
      .root_o    (root)
   );

   assign irq_o = |root;

   // padded lookup tables for the indirect windows
   logic [7:0] lat_tab [TABN];
   logic [7:0] raw_tab [TABN];
   logic [7:0] mst_tab [MST_REGS];

   for (genvar t = 0; t < TABN; t++) begin : g_tab
      if (t < NUM_BLK) begin : g_real
         assign lat_tab[t] = pend_all[t*LANES +: LANES];
         assign raw_tab[t] = src_s[t*LANES +: LANES];
      end else begin : g_pad
         assign lat_tab[t] = '0;
         assign raw_tab[t] = '0;
      end
   end

   for (genvar m = 0; m < MST_REGS; m++) begin : g_mst
      if (m < NUM_MST) begin : g_real
         assign mst_tab[m] = mst_bits[m*8 +: 8];
      end else begin : g_pad
         assign mst_tab[m] = '0;
      end
   end

   logic           sel_ok;
   logic [BIW-1:0] blk_idx;

   assign sel_ok  = int'(blk_sel) < NUM_BLK;
   assign blk_idx = blk_sel[BIW-1:0];

   always_comb begin
      rd_data = '0;
      if (addr == A_ROOT)
         rd_data = root;
      else if (addr == A_SEL)
         rd_data = blk_sel;
      else if (addr == A_LATCH)
         rd_data = sel_ok ? lat_tab[blk_idx] : 8'h00;
      else if (addr == A_RAW)
         rd_data = sel_ok ? raw_tab[blk_idx] : 8'h00;
      else begin
         for (int m = 0; m < MST_REGS; m++)
            if (addr == ADDR_W'(BASE + OFS_MST0 + m))
               rd_data = mst_tab[m];
      end
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
   parameter int          ADDR_W = 10,
   parameter int unsigned BASE   = 'h1C0,
   parameter int          CFGW   = 768
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [7:0]        wr_data,
   input logic [7:0]        rd_data,
   input logic              irq_o,
   input logic [7:0]        blk_sel,
   input logic [CFGW-1:0]   cfg_all
);
   localparam logic [ADDR_W-1:0] A_ROOT = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(BASE + 5);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(BASE + 7);
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(BASE + 8);

   AST_ROOT_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_ROOT) |-> !rd_data[0]); // R3
   AST_IRQ_IDLE_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_ROOT && !irq_o) |-> (rd_data == 8'h00)); // R11
   AST_IRQ_BUSY_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_ROOT && irq_o) |-> (rd_data != 8'h00)); // R11
   AST_SEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SEL) |=> (blk_sel == $past(wr_data))); // R1
   AST_CFG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CFG && !wr_data[7]) |=> $stable(cfg_all)); // R5
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr < A_ROOT || addr > A_LAST) |-> (rd_data == 8'h00)); // R1
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !irq_o); // R12
endmodule

bind irq_aggregator irqagg_chk #(
   .ADDR_W (ADDR_W),
   .BASE   (BASE),
   .CFGW   (NUM_SRC*3)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .irq_o   (irq_o),
   .blk_sel (blk_sel),
   .cfg_all (cfg_all)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
   localparam int          NS = 256;
   localparam int          AW = 10;
   localparam int unsigned BA = 'h1C0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic          irq;

   always #5 clk = ~clk;

   irq_aggregator #(.NUM_SRC(NS), .ADDR_W(AW), .BASE(BA)) u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb[$];
   logic rd_vld = 1'b0;

   task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic wr(int ofs, logic [7:0] d);
      @(posedge clk); #1;
      addr = AW'(BA + ofs); wr_data = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0; addr = '0;
   endtask

   // driver: pushes the expected value, monitor compares it
   task automatic rd(int ofs, logic [7:0] exp, string tag);
      exp_t e;
      e.exp = exp; e.tag = tag;
      @(posedge clk); #1;
      addr = AW'(BA + ofs); rd_vld = 1'b1;
      sb.push_back(e);
      @(posedge clk); #1;
      rd_vld = 1'b0; addr = '0;
   endtask

   task automatic chk_irq(logic exp, string tag);
      @(negedge clk);
      check(irq === exp, tag, {7'd0, irq}, {7'd0, exp});
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rd_vld) begin
         exp_t e;
         if (sb.size() == 0) begin
            check(1'b0, "scoreboard underflow", rd_data, 8'h00);
         end else begin
            e = sb.pop_front();
            check(rd_data === e.exp, e.tag, rd_data, e.exp);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R12 reset state
      chk_irq(1'b0, "R12 irq after reset");
      rd(0, 8'h00, "R12 root after reset");
      rd(5, 8'h00, "R12 select after reset");
      rd(6, 8'h00, "R12 latched after reset");
      // R12 reset config is masked; R10 raw shows level
      src[3] = 1'b1; idle(6);
      rd(6, 8'h00, "R12 masked source stays idle");
      rd(8, 8'h08, "R10 raw level block 0");
      chk_irq(1'b0, "R12 irq masked");
      src[3] = 1'b0; idle(4);

      // R6 rising edge on source 10 (block 1 bit 2), falling masked
      wr(5, 8'h01);
      wr(7, 8'hA2);
      src[10] = 1'b1; idle(5);
      rd(6, 8'h04, "R6 rising sets pending");
      rd(1, 8'h02, "R2 master0 shows block1");
      rd(0, 8'h02, "R3 root bit1 for master0");
      chk_irq(1'b1, "R11 irq high");
      src[10] = 1'b0; idle(5);
      rd(6, 8'h04, "R6 masked falling no effect");
      wr(7, 8'hAA); idle(2);
      rd(6, 8'h00, "R8 clear pending");
      chk_irq(1'b0, "R11 irq low after clear");

      // R6 falling edge, rising masked
      wr(7, 8'hA4);
      src[10] = 1'b1; idle(5);
      rd(6, 8'h00, "R6 masked rising no effect");
      src[10] = 1'b0; idle(5);
      rd(6, 8'h04, "R6 falling sets pending");
      wr(7, 8'hAC); idle(2);
      rd(6, 8'h00, "R8 clear falling pending");

      // R5 write without strobe is ignored
      wr(7, 8'h20);
      src[10] = 1'b1; idle(5);
      rd(6, 8'h00, "R5 unstrobed write ignored");
      src[10] = 1'b0; idle(5);
      wr(7, 8'hAC); idle(2);

      // R7 level mode on source 200 (block 25 bit 0, master 3)
      wr(5, 8'h19);
      wr(7, 8'h83);
      src[200] = 1'b1; idle(5);
      rd(6, 8'h01, "R7 high level sets pending");
      rd(4, 8'h02, "R2 master3 shows block25");
      rd(0, 8'h10, "R3 root bit4 for master3");
      wr(7, 8'h8B); idle(4);
      rd(6, 8'h01, "R7 relatch after clear while active");
      src[200] = 1'b0; idle(5);
      wr(7, 8'h8B); idle(4);
      rd(6, 8'h00, "R7 low level masked stays clear");

      // R4 two masters at once, then R9 disable
      wr(5, 8'h01);
      wr(7, 8'hA2);
      src[10] = 1'b1;
      src[200] = 1'b1; idle(6);
      rd(0, 8'h12, "R4 root merges two masters");
      wr(5, 8'h19);
      wr(7, 8'h86); idle(2);
      rd(6, 8'h00, "R9 disable clears pending");
      rd(0, 8'h02, "R4 root drops master3");
      src[200] = 1'b0; idle(5);
      src[200] = 1'b1; idle(5);
      rd(6, 8'h00, "R9 disabled source stays idle");
      wr(5, 8'h01);
      wr(7, 8'hAA); idle(2);
      chk_irq(1'b0, "R11 irq low after all cleared");
      src[10] = 1'b0;

      // R1 / R12 out-of-range block and unmapped address
      wr(5, 8'h28);
      rd(5, 8'h28, "R1 select readback");
      rd(6, 8'h00, "R12 latched out of range");
      rd(8, 8'h00, "R12 raw out of range");
      rd(9, 8'h00, "R1 unmapped offset");

      // R10 raw pattern in block 2
      wr(5, 8'h02);
      src[23:16] = 8'h5A; idle(4);
      rd(8, 8'h5A, "R10 raw pattern block2");
      rd(6, 8'h00, "R12 block2 still masked");

      idle(3);
      if (sb.size() != 0) check(1'b0, "scoreboard leftover", 8'(sb.size()), 8'h00);
      summary();
   end
endmodule